// File: doc/BRIEF.md
# DDR2 Command Sequencer with Latency Tracking

This block sits between an access arbiter and the DDR2 physical layer. It takes one granted access at a time: read or write, bank, row, column and byte mask. It turns that access into a correctly spaced series of commands on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. The block keeps a table of the row held open in every bank. A hit goes straight to the column command. An access to a closed bank first gets an activate. An access that collides with a different open row first gets a single-bank precharge and then an activate. A separate request closes every bank at once.

For every column command the block also marks the data beats. Bursts are always eight beats, which is four clock cycles. A read-data window opens after the programmed CAS latency, and a write-data window opens one cycle earlier than that. During the write window the byte-mask pins carry the mask of the write. Minimum gaps are counted down per bank for activate-to-column and precharge-to-activate. Gaps are counted globally for column-to-column, read-to-write and write-to-read. Cycles with no command are deselect cycles.

Top module: `ddr2_cmd_seq`

## Requirements
- R1: After reset, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1, `rd_valid` and `wr_valid` are 0, `dm_o` is all ones, and `req_ready` is 1.
- R2: The pin codes on (`cs_n`,`ras_n`,`cas_n`,`we_n`) are: activate 0011, read 0101, write 0100, precharge 0010. A cycle with no command carries 1111, with bank and address at zero.
- R3: An access to a closed bank issues an activate, with the bank on `ba_o` and the row on `addr_o`, one cycle after acceptance once that bank's precharge gap has run out. The column command follows exactly `cfg_trcd` cycles later unless another rule holds it back. It carries the column on `addr_o`, with bit 10 low. A `cfg_trcd` of 0 behaves as 1.
- R4: An access to an open bank whose open row differs issues a precharge for that bank, with `addr_o` all zero, one cycle after acceptance. The activate follows exactly `cfg_trp` cycles later. A `cfg_trp` of 0 behaves as 1.
- R5: A precharge-all request issues the precharge code with `addr_o` bit 10 high and `ba_o` zero, one cycle after acceptance. It closes every bank and starts the `cfg_trp` gap on each one. A later access to a bank that was open then begins with an activate, not a precharge.
- R6: `rd_valid` is high for exactly 4 cycles for each read. The window starts CL cycles after the read command appears on the pins.
- R7: `wr_valid` is high for exactly 4 cycles for each write. The window starts CL-1 cycles after the write command. While it is high, `dm_o` equals the write's mask, where a 1 masks a byte. At all other times `dm_o` is all ones.
- R8: The effective CL is `cfg_cl` for codes 2 to 5. Codes 0 and 1 act as 2, and codes 6 and 7 act as 5.
- R9: `cfg_twtr` holds the write-to-read gap minus one. A read follows a write's last data cycle by at least `cfg_twtr`+1 cycles, so the read comes at least CL+3+`cfg_twtr` cycles after the write command. The gap is exact when only this rule delays the read.
- R10: Column commands are at least 4 cycles apart. A write comes at least 6 cycles after a read. Read and write windows never overlap.
- R11: An access to the open row issues only its column command, one cycle after acceptance when no gap holds it back. `req_ready` is low while an access or precharge-all is pending and while `pall_req` is high. `pall_req` is taken in any cycle in which the block has nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cl | input | 3 | CAS latency code |
| cfg_trcd | input | TW | Activate-to-column gap in cycles |
| cfg_trp | input | TW | Precharge-to-activate gap in cycles |
| cfg_twtr | input | TW | Last write data to read gap, minus one |
| pall_req | input | 1 | Request to close all banks |
| req_valid | input | 1 | Access offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_mask | input | MASK_W | Byte mask for a write, 1 = masked |
| req_ready | output | 1 | Access accepted when high together with req_valid |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank pins |
| addr_o | output | ROW_W | Address pins |
| rd_valid | output | 1 | Read data window |
| wr_valid | output | 1 | Write data window |
| dm_o | output | MASK_W | Byte-mask pins |

## Verification
Two functions can fall in the same cycle here: issuing a new row command, and carrying the data window of an earlier column command. A conflicting access is sent right after a read, so its precharge and activate go out while that read's window is still open. A second hit read is accepted the cycle after the previous read, so its window abuts the earlier one. These overlaps are provoked across a sweep of every CAS code and small timing values. Each command's cycle is checked against a maximum over the competing gap rules. Both windows and the mask pins are checked every cycle against a model built from the observed command times and the effective latency.

// File: rtl/ddr2_cmd_seq.sv
module ddr2_cmd_seq #(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int MASK_W = 4,
  parameter int TW     = 4,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_cl,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_twtr,
  input  logic              pall_req,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [MASK_W-1:0] req_mask,
  output logic              req_ready,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              rd_valid,
  output logic              wr_valid,
  output logic [MASK_W-1:0] dm_o
);
  // column fits below bit 10, which marks close-all
  localparam int PIPE  = 9;
  localparam int WTR_W = TW + 2;

  typedef enum logic [2:0] {C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_PALL} cmd_e;

  logic              busy, h_pall, h_wr;
  logic [BA_W-1:0]   h_ba;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [MASK_W-1:0] h_mask;

  logic [BANKS-1:0]  open_q;
  logic [ROW_W-1:0]  row_q [BANKS];
  logic [TW-1:0]     rcd_q [BANKS];
  logic [TW-1:0]     rp_q  [BANKS];
  logic [2:0]        col_q, rtw_q;
  logic [WTR_W-1:0]  wtr_q;

  logic [PIPE-1:0]   rdp_q, wrp_q;
  logic [MASK_W-1:0] dmp_q [PIPE];

  logic [2:0]        cl_eff, wl_eff;
  logic [PIPE-1:0]   rwin, wwin;
  logic              take_pall, take_req;
  cmd_e              cmd;

  function automatic logic [TW-1:0] gap_load(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign cl_eff    = (cfg_cl < 3'd2) ? 3'd2 : (cfg_cl > 3'd5) ? 3'd5 : cfg_cl;
  assign wl_eff    = cl_eff - 3'd1;
  assign rwin      = PIPE'(4'hF) << cl_eff;
  assign wwin      = PIPE'(4'hF) << wl_eff;
  assign take_pall = !busy && pall_req;
  assign take_req  = !busy && !pall_req && req_valid;
  assign req_ready = !busy && !pall_req;
  assign rd_valid  = rdp_q[0];
  assign wr_valid  = wrp_q[0];
  assign dm_o      = dmp_q[0];

  always_comb begin
    cmd = C_NONE;
    if (busy) begin
      if (h_pall)
        cmd = C_PALL;
      else if (!open_q[h_ba]) begin
        if (rp_q[h_ba] == '0) cmd = C_ACT;
      end else if (row_q[h_ba] != h_row)
        cmd = C_PRE;
      else if (rcd_q[h_ba] == '0 && col_q == '0) begin
        if (h_wr) begin
          if (rtw_q == '0) cmd = C_WR;
        end else if (wtr_q == '0)
          cmd = C_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      h_pall <= 1'b0;
      h_wr   <= 1'b0;
      h_ba   <= '0;
      h_row  <= '0;
      h_col  <= '0;
      h_mask <= '1;
    end else if (take_pall || take_req) begin
      busy   <= 1'b1;
      h_pall <= take_pall;
      h_wr   <= req_write;
      h_ba   <= req_bank;
      h_row  <= req_row;
      h_col  <= req_col;
      h_mask <= req_mask;
    end else if (cmd == C_RD || cmd == C_WR || cmd == C_PALL) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < BANKS; b++) begin
        row_q[b] <= '0;
        rcd_q[b] <= '0;
        rp_q[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (cmd == C_PALL || (cmd == C_PRE && h_ba == BA_W'(b))) begin
          open_q[b] <= 1'b0;
          rp_q[b]   <= gap_load(cfg_trp);
        end else if (rp_q[b] != '0)
          rp_q[b] <= rp_q[b] - 1'b1;
        if (cmd == C_ACT && h_ba == BA_W'(b)) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= h_row;
          rcd_q[b]  <= gap_load(cfg_trcd);
        end else if (rcd_q[b] != '0)
          rcd_q[b] <= rcd_q[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      rtw_q <= '0;
      wtr_q <= '0;
    end else begin
      if (cmd == C_RD || cmd == C_WR) col_q <= 3'd3;
      else if (col_q != '0)           col_q <= col_q - 1'b1;
      if (cmd == C_RD)                rtw_q <= 3'd5;
      else if (rtw_q != '0)           rtw_q <= rtw_q - 1'b1;
      if (cmd == C_WR)
        wtr_q <= WTR_W'(cl_eff) + WTR_W'(cfg_twtr) + WTR_W'(2);
      else if (wtr_q != '0)
        wtr_q <= wtr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdp_q <= '0;
      wrp_q <= '0;
      for (int k = 0; k < PIPE; k++) dmp_q[k] <= '1;
    end else begin
      rdp_q <= (rdp_q >> 1) | ((cmd == C_RD) ? rwin : '0);
      wrp_q <= (wrp_q >> 1) | ((cmd == C_WR) ? wwin : '0);
      for (int k = 0; k < PIPE - 1; k++)
        dmp_q[k] <= (cmd == C_WR && wwin[k]) ? h_mask : dmp_q[k+1];
      dmp_q[PIPE-1] <= (cmd == C_WR && wwin[PIPE-1]) ? h_mask : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba_o   <= '0;
      addr_o <= '0;
      case (cmd)
        C_ACT: begin
          {cs_n, ras_n, cas_n, we_n} <= 4'b0011;
          ba_o   <= h_ba;
          addr_o <= h_row;
        end
        C_RD: begin
          {cs_n, ras_n, cas_n, we_n} <= 4'b0101;
          ba_o   <= h_ba;
          addr_o <= ROW_W'(h_col);
        end
        C_WR: begin
          {cs_n, ras_n, cas_n, we_n} <= 4'b0100;
          ba_o   <= h_ba;
          addr_o <= ROW_W'(h_col);
        end
        C_PRE: begin
          {cs_n, ras_n, cas_n, we_n} <= 4'b0010;
          ba_o   <= h_ba;
        end
        C_PALL: begin
          {cs_n, ras_n, cas_n, we_n} <= 4'b0010;
          addr_o <= ROW_W'(1) << 10;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_cmd_seq_chk.sv
module ddr2_cmd_seq_chk #(
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              rd_valid,
  input logic              wr_valid,
  input logic [MASK_W-1:0] dm_o,
  input logic              req_valid,
  input logic              req_ready
);
  logic       col_cmd;
  logic [2:0] since_col;
  logic [3:0] rd_run, wr_run;

  assign col_cmd = !cs_n && ras_n && !cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_col <= 3'd7;
      rd_run    <= '0;
      wr_run    <= '0;
    end else begin
      since_col <= col_cmd ? 3'd0 : (since_col == 3'd7 ? 3'd7 : since_col + 3'd1);
      rd_run    <= rd_valid ? rd_run + 4'd1 : 4'd0;
      wr_run    <= wr_valid ? wr_run + 4'd1 : 4'd0;
    end
  end

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ras_n && cas_n && we_n));

  assert_colgap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |-> since_col >= 3'd3);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  assert_dm_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> dm_o == '1);

  assert_rd_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (rd_run != 4'd0 && rd_run[1:0] == 2'd0));

  assert_wr_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) |-> (wr_run != 4'd0 && wr_run[1:0] == 2'd0));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind ddr2_cmd_seq ddr2_cmd_seq_chk #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .rd_valid(rd_valid), .wr_valid(wr_valid), .dm_o(dm_o),
  .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/ddr2_cmd_seq_test.sv
module ddr2_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 8, ROW_W = 13, COL_W = 10, MASK_W = 4, TW = 4, BA_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_cl = 3'd2;
  logic [TW-1:0] cfg_trcd = '0, cfg_trp = '0, cfg_twtr = '0;
  logic pall_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [BA_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [MASK_W-1:0] req_mask = '1;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_valid, wr_valid;
  logic [BA_W-1:0] ba_o;
  logic [ROW_W-1:0] addr_o;
  logic [MASK_W-1:0] dm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_cmd_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .MASK_W(MASK_W), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_twtr(cfg_twtr), .pall_req(pall_req), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_mask(req_mask),
    .req_ready(req_ready), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba_o(ba_o), .addr_o(addr_o), .rd_valid(rd_valid), .wr_valid(wr_valid), .dm_o(dm_o));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  int nc = 0;
  int c_cyc [64];
  logic [2:0] c_code [64];
  logic [BA_W-1:0] c_ba [64];
  logic [ROW_W-1:0] c_addr [64];
  int rh0 = -100, rh1 = -100, wh0 = -100, wh1 = -100;
  logic [MASK_W-1:0] wm0 = '1, wm1 = '1, cur_mask = '1;
  int e = 2;
  bit mon_en = 0;
  bit er, ew0, ew1;
  logic [MASK_W-1:0] edm;

  always @(negedge clk) begin
    if (mon_en) begin
      er  = (cyc >= rh0 + e && cyc <= rh0 + e + 3) || (cyc >= rh1 + e && cyc <= rh1 + e + 3);
      ew0 = (cyc >= wh0 + e - 1 && cyc <= wh0 + e + 2);
      ew1 = (cyc >= wh1 + e - 1 && cyc <= wh1 + e + 2);
      edm = ew0 ? wm0 : (ew1 ? wm1 : '1);
      tests++;
      if (rd_valid !== er || wr_valid !== (ew0 || ew1) || dm_o !== edm) begin
        fails++;
        $display("FAIL R6/R7/R8 window at cycle %0d: rd %b wr %b dm %b, expected rd %b wr %b dm %b",
                 cyc, rd_valid, wr_valid, dm_o, er, ew0 || ew1, edm);
      end
    end
    if (rst_n && cs_n === 1'b0) begin
      if (nc < 64) begin
        c_cyc[nc]  = cyc;
        c_code[nc] = {ras_n, cas_n, we_n};
        c_ba[nc]   = ba_o;
        c_addr[nc] = addr_o;
      end
      if ({ras_n, cas_n, we_n} == 3'b101) begin rh1 = rh0; rh0 = cyc; end
      if ({ras_n, cas_n, we_n} == 3'b100) begin
        wh1 = wh0; wh0 = cyc; wm1 = wm0; wm0 = cur_mask;
      end
      nc++;
    end
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_cmd(input int k, input logic [2:0] code, input int bank, input int addr,
                           input int when, input string tag);
    check(k < nc && c_code[k] == code, {tag, " code"}, int'(c_code[k]), int'(code));
    check(int'(c_ba[k]) == bank, {tag, " bank"}, int'(c_ba[k]), bank);
    check(int'(c_addr[k]) == addr, {tag, " address"}, int'(c_addr[k]), addr);
    check(c_cyc[k] == when, {tag, " cycle"}, c_cyc[k], when);
  endtask

  task automatic access(input bit wr, input int b, input int row, input int col,
                        input logic [MASK_W-1:0] m, output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = BA_W'(b);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_mask = m;
    if (wr) cur_mask = m;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic do_pall(output int acc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    pall_req = 1'b1;
    #1;
    check(req_ready == 1'b0, "R11 ready low while pall_req high", int'(req_ready), 0);
    @(negedge clk);
    acc = cyc;
    pall_req = 1'b0;
  endtask

  task automatic wait_n(input int n);
    while (nc < n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a, pc, act1, rd1, wr2, rd3, pre, act4, rd4, rd6, act5, wr5, tr, tp;
    logic [MASK_W-1:0] m1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 pins idle after reset",
          int'({cs_n, ras_n, cas_n, we_n}), 15);
    check(!rd_valid && !wr_valid, "R1 windows closed after reset", int'({rd_valid, wr_valid}), 0);
    check(dm_o == '1, "R1 mask all ones after reset", int'(dm_o), 15);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    mon_en = 1;

    for (int cl = 0; cl < 8; cl++)
      for (int trcd = 0; trcd < 4; trcd++)
        for (int trp = 0; trp < 4; trp++)
          for (int twtr = 0; twtr < 3; twtr++) begin
            cfg_cl = 3'(cl); cfg_trcd = TW'(trcd); cfg_trp = TW'(trp); cfg_twtr = TW'(twtr);
            e  = (cl < 2) ? 2 : ((cl > 5) ? 5 : cl);
            tr = (trcd == 0) ? 1 : trcd;
            tp = (trp == 0) ? 1 : trp;
            m1 = MASK_W'(cl + trcd + trp);
            nc = 0;

            do_pall(a); wait_n(1);
            pc = a + 1;
            check_cmd(0, 3'b010, 0, 1 << 10, pc, "R5 precharge-all");

            access(0, 1, 5, 8, '1, a); wait_n(3);
            act1 = mx(pc + tp, a + 1);
            check_cmd(1, 3'b011, 1, 5, act1, "R5 activate after close-all");
            rd1 = act1 + tr;
            check_cmd(2, 3'b101, 1, 8, rd1, "R3 read after activate");

            access(1, 1, 5, 16, m1, a); wait_n(4);
            wr2 = mx(a + 1, rd1 + 6);
            check_cmd(3, 3'b100, 1, 16, wr2, "R10 write after read");

            access(0, 1, 5, 24, '1, a); wait_n(5);
            rd3 = mx(a + 1, wr2 + e + 3 + twtr);
            check_cmd(4, 3'b101, 1, 24, rd3, "R9 read after write");

            access(0, 1, 9, 32, '1, a); wait_n(8);
            pre = a + 1;
            check_cmd(5, 3'b010, 1, 0, pre, "R4 precharge on conflict");
            act4 = pre + tp;
            check_cmd(6, 3'b011, 1, 9, act4, "R4 activate after precharge");
            rd4 = mx(act4 + tr, rd3 + 4);
            check_cmd(7, 3'b101, 1, 32, rd4, "R3 read after reopen");

            access(0, 1, 9, 40, '1, a); wait_n(9);
            rd6 = mx(a + 1, rd4 + 4);
            check_cmd(8, 3'b101, 1, 40, rd6, "R11 hit read spaced per R10");

            access(1, 2, 3, 48, ~m1, a); wait_n(11);
            act5 = a + 1;
            check_cmd(9, 3'b011, 2, 3, act5, "R3 activate closed bank");
            wr5 = mx(act5 + tr, rd6 + 6);
            check_cmd(10, 3'b100, 2, 48, wr5, "R10 write after hit read");

            repeat (40) @(negedge clk);
            check(nc == 11, "R2 deselect while idle", nc, 11);
          end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule